// File: doc/BRIEF.md
# Bit-Serial Adder with Shift-Register Operands

This block adds two W-bit words with a single one-bit full adder used again on each clock cycle. While reset is held, both operand words are copied into right-shifting registers, the result register is cleared and the incoming carry is latched into the carry flip-flop. After reset is released, each cycle with `run` high applies the lowest remaining bit of each operand to the full adder. The sum bit is shifted into the top of the result register, and the new carry is stored for the next cycle.

After W enabled cycles the result register holds the sum in normal bit order. `done` then goes high and stays high, and `cout` shows the final carry. From that point `run` has no effect. Raising reset at any time discards partial work and loads fresh operands. The block suits designs that can spend W cycles on an addition to save adder area.

Top module: `bit_serial_adder`

## Requirements
- R1: On a clock edge with `rst` high, the operands are loaded from `a_in`/`b_in` and `cin` is latched as the first carry. On the next cycle, `sum_out`, `sum_bit`, `cout` and `done` are all 0.
- R2: Each enabled cycle uses operand bit k, starting at k=0 (the least significant bit). The new sum bit enters `sum_out[W-1]` and the older contents move one place toward bit 0. After k steps, `sum_out[W-1 -: k]` holds the low k bits of a+b+cin.
- R3: The carry produced at step k is the carry into step k+1. `cin` is the carry into step 0 only.
- R4: A cycle with `run` low and `done` low changes no output, and it does not advance the addition.
- R5: `done` rises after exactly W enabled cycles and stays high until the next reset.
- R6: While `done` is high, `run` is ignored: `sum_out`, `sum_bit` and `cout` hold their values.
- R7: `cout` is 0 while `done` is low. Once `done` is high, `cout` equals bit W of a+b+cin.
- R8: Reset during an addition drops the partial result. The next addition runs on the newly loaded operands and carry.
- R9: After each enabled step, `sum_bit` equals the sum bit just produced, which is the bit now in `sum_out[W-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads operands and carry |
| run | input | 1 | Step enable for one bit per cycle |
| a_in | input | W | First operand, sampled during reset |
| b_in | input | W | Second operand, sampled during reset |
| cin | input | 1 | Carry into the first step, sampled during reset |
| sum_out | output | W | Result register, complete when `done` is high |
| sum_bit | output | 1 | Sum bit produced in the latest step |
| cout | output | 1 | Final carry, 0 until `done` |
| done | output | 1 | High after W steps |

## Verification
Two events can fall in the same cycle: the final step (which raises `done` and sets `cout`) and a `run` request that would be one step too many. The bench keeps `run` high for several cycles past the W-th step and also toggles it mid-addition. The second case also puts a reset on the same edge as an ongoing step. A behavioural model computes the expected partial sum from integer arithmetic on the low k bits. It checks each clock that the extra requests leave `sum_out`, `sum_bit` and `cout` frozen, and that a coincident reset always wins.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction
endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder
  import bsa_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = fa_sum(x, y, ci);
    co = fa_carry(x, y, ci);
  end
endmodule

// File: rtl/bsa_shift_reg.sv
module bsa_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load)
      q <= par_in;
    else if (shift)
      q <= {ser_in, q[W-1:1]};
  end
endmodule

// File: rtl/bsa_step_counter.sv
module bsa_step_counter #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic last,
  output logic done
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt;

  assign last = (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (en && !done) begin
      cnt <= cnt + 1'b1;
      if (last)
        done <= 1'b1;
    end
  end
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  output logic [W-1:0] sum_out,
  output logic         sum_bit,
  output logic         cout,
  output logic         done
);
  logic [W-1:0] a_q, b_q;
  logic         carry_q;
  logic         s_now, c_next;
  logic         step, last;

  assign step = run && !done;

  bsa_step_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(run), .last(last), .done(done)
  );

  bsa_shift_reg #(.W(W)) u_a (
    .clk(clk), .load(rst), .shift(step), .par_in(a_in), .ser_in(1'b0), .q(a_q)
  );

  bsa_shift_reg #(.W(W)) u_b (
    .clk(clk), .load(rst), .shift(step), .par_in(b_in), .ser_in(1'b0), .q(b_q)
  );

  bsa_shift_reg #(.W(W)) u_s (
    .clk(clk), .load(rst), .shift(step), .par_in('0), .ser_in(s_now), .q(sum_out)
  );

  bsa_full_adder u_fa (
    .x(a_q[0]), .y(b_q[0]), .ci(carry_q), .s(s_now), .co(c_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= cin;
      sum_bit <= 1'b0;
      cout    <= 1'b0;
    end else if (step) begin
      carry_q <= c_next;
      sum_bit <= s_now;
      if (last)
        cout <= c_next;
    end
  end
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic [W-1:0] sum_out,
  input logic         sum_bit,
  input logic         cout,
  input logic         done
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (sum_out == '0 && !sum_bit && !cout && !done));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !done) |=> ($stable(sum_out) && $stable(sum_bit) && !done));

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_frozen_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(sum_out) && $stable(sum_bit) && $stable(cout)));

  p_cout_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> !cout);

  p_bit_matches_msb_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !done) |=> (sum_bit == sum_out[W-1]));
endmodule

bind bit_serial_adder bsa_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .sum_out(sum_out),
  .sum_bit(sum_bit), .cout(cout), .done(done)
);

// File: tb/tb_bit_serial_adder.sv
module tb_bit_serial_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_out;
  logic         sum_bit, cout, done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference state
  longint ma = 0, mb = 0, mc = 0;
  int     k  = 0;
  string  phase = "R1 reset";

  always #10 clk = ~clk;

  bit_serial_adder #(.W(W)) dut (
    .clk(clk), .rst(rst), .run(run), .a_in(a_in), .b_in(b_in), .cin(cin),
    .sum_out(sum_out), .sum_bit(sum_bit), .cout(cout), .done(done)
  );

  always @(posedge clk) begin
    if (rst) begin
      ma = longint'(a_in); mb = longint'(b_in); mc = longint'(cin); k = 0;
    end else if (run && k < W) begin
      k = k + 1;
    end
  end

  function automatic longint low_sum(int n);
    longint m = (64'sd1 <<< n);
    return (ma % m) + (mb % m) + mc;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] k=%0d actual=%0h expected=%0h", tag, phase, k, act, exp);
    end
  endtask

  task automatic compare();
    longint p, e_sum, e_bit, e_cout;
    if (k == 0) begin
      e_sum = 0; e_bit = 0;
    end else begin
      p     = low_sum(k);
      e_sum = ((p % (64'sd1 <<< k)) <<< (W - k));
      e_bit = (p >>> (k - 1)) & 1;
    end
    e_cout = (k == W) ? ((low_sum(W) >>> W) & 1) : 0;
    check("R2 sum_out", longint'(sum_out), e_sum);
    check("R9 sum_bit", longint'(sum_bit), e_bit);
    check("R7 cout",    longint'(cout),    e_cout);
    check("R5 done",    longint'(done),    (k == W) ? 1 : 0);
  endtask

  task automatic cyc(logic r, logic rn);
    @(negedge clk);
    if (!rst) compare();
    rst = r; run = rn;
  endtask

  task automatic add(logic [W-1:0] a, logic [W-1:0] b, logic c, int extra);
    @(negedge clk);
    rst = 1'b1; a_in = a; b_in = b; cin = c;
    cyc(1'b0, 1'b1);
    for (int i = 0; i < W + extra; i++) cyc(1'b0, 1'b1);
  endtask

  initial begin
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    phase = "R1 reset";
    compare();
    phase = "R2 basic";
    add(8'h5A, 8'h3C, 1'b0, 0);
    phase = "R3 carry chain";
    add(8'hFF, 8'h01, 1'b1, 0);
    phase = "R6 extra run after done";
    add(8'hFF, 8'hFF, 1'b1, 4);
    phase = "R3 zeros with cin";
    add(8'h00, 8'h00, 1'b1, 1);
    phase = "R4 run gaps";
    @(negedge clk); rst = 1'b1; a_in = 8'hA7; b_in = 8'h6B; cin = 1'b1;
    for (int i = 0; i < 3 * W; i++) cyc(1'b0, (i % 3) != 1);
    phase = "R8 reset mid add";
    @(negedge clk); rst = 1'b1; a_in = 8'h99; b_in = 8'h77; cin = 1'b0;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    a_in = 8'h0F; b_in = 8'hF1; cin = 1'b1;
    for (int i = 0; i < W + 2; i++) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule